// File: doc/BRIEF.md
# Cascaded Input Serializer Chain Reader

This block is the master side of a serial link to a chain of cascaded serializer chips, each of which reports eight digital field inputs. A single start pulse makes the block drop chip select, clock the whole chain out in one frame and raise it again. It then splits the frame into one slot per chip. In status mode each chip slot holds an input byte followed by a diagnostic byte. In the lean mode a slot holds the input byte alone. The block registers the resulting input vector and a per-chip fault vector.

In status mode the diagnostic byte of every chip is decoded. The block checks a 5-bit CRC of the input byte and extracts the overtemperature alarm and the two supply-voltage indications. These are combined with external fault lines into a per-chip fault decision. A faulting chip has its eight inputs forced to zero, while the healthy chips of the same chain are still reported. The block also drives the mode-select level and per-chip debounce-select lines toward the chain.

Top module: `serchain_reader`

## Requirements
- R1: A frame holds chip select low throughout and issues exactly 8·W·N serial clock cycles, where W is 2 in status mode and 1 in lean mode. The serial clock rests at its idle polarity whenever chip select is high, and the first bit is sampled without any preceding clock.
- R2: After a start pulse, done_o rises for exactly one cycle, and updated outputs are visible in that cycle. The outputs then hold unchanged until the next done_o. A start pulse that arrives while a frame is in progress is dropped.
- R3: The line carries chip 0's slot first, and every byte is sent MSB first. In status mode a chip's input byte precedes its status byte. Bit k of data_o is bit k mod 8 of chip k/8's input byte.
- R4: In status mode, status bits [7:3] are compared with the CRC of the input byte. The CRC uses generator x^5+x^4+x^2+1, starts from zero and takes the data MSB first. A mismatch sets that chip's crc_err_o bit and marks the chip faulty.
- R5: Status bit 1 at 1 sets otemp_o for that chip and marks the chip faulty.
- R6: Status bit 2 at 0 sets uv_alarm_o and marks the chip faulty. Status bit 0 at 0 sets uv_warn_o but does not by itself mark the chip faulty.
- R7: With ignore_uv_i high, uv_alarm_o and uv_warn_o read 0, and the external fault lines have no effect on fault_o.
- R8: An external fault line is active high and is sampled when the frame ends. With FAULT_W equal to N, line i belongs to chip i. With FAULT_W equal to 1, the single line applies to every chip.
- R9: A chip whose fault_o bit is 1 reports its eight data_o bits as 0, while the other chips report their input bytes unchanged.
- R10: In lean mode the frame is N bytes long. crc_err_o, otemp_o, uv_alarm_o and uv_warn_o read 0, and only the fault lines can fault a chip. modesel_o is 1 in lean mode and 0 in status mode.
- R11: db0_o[i] follows dbnc_sel_i[2i] and db1_o[i] follows dbnc_sel_i[2i+1]. These lines are updated only while no frame is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Single-cycle request for one frame |
| ignore_uv_i | input | 1 | Disregard supply-voltage flags and fault lines |
| fault_pin_i | input | FAULT_W | External fault lines, active high |
| dbnc_sel_i | input | 2·N_CHIPS | Debounce code, two bits per chip |
| miso_i | input | 1 | Serial data from the chain |
| sclk_o | output | 1 | Serial clock |
| cs_n_o | output | 1 | Chip select, active low |
| modesel_o | output | 1 | Mode-select level for the chain |
| db0_o | output | N_CHIPS | Debounce select, low bit |
| db1_o | output | N_CHIPS | Debounce select, high bit |
| done_o | output | 1 | Frame complete, one cycle |
| data_o | output | 8·N_CHIPS | Input bits, faulting chips masked |
| fault_o | output | N_CHIPS | Per-chip fault decision |
| crc_err_o | output | N_CHIPS | Per-chip CRC mismatch |
| otemp_o | output | N_CHIPS | Per-chip overtemperature |
| uv_alarm_o | output | N_CHIPS | Per-chip undervoltage alarm |
| uv_warn_o | output | N_CHIPS | Per-chip undervoltage warning |

## Verification
A healthy frame with a distinct, asymmetric input byte per chip shows whether slot order, byte order and bit order are all right, since a swap of any of them moves recognisable bytes. Separate frames then corrupt one status field in one chip: a flipped CRC bit, the overtemperature bit, the alarm bit, and the warning bit. The flag lands on that chip alone, and only the alarm-class faults blank that chip's data. The same supply errors are repeated with the ignore option and with fault lines active, in both the per-chip and the shared-line build. The lean-mode build confirms the shorter frame and the silent status flags. A start issued mid-frame, together with a debounce change issued mid-frame, checks that an ongoing frame is left undisturbed.

// File: rtl/serchain_pkg.sv
package serchain_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_CLK,
    ST_HOLD,
    ST_FIN
  } rd_state_e;

  // 5-bit check over one byte, generator x^5+x^4+x^2+1, zero seed, MSB first
  function automatic logic [4:0] crc5_calc(input logic [7:0] d);
    logic [4:0] c;
    logic       fb;
    c = 5'd0;
    for (int i = 7; i >= 0; i--) begin
      fb = c[4] ^ d[i];
      c  = {c[3:0], 1'b0};
      if (fb) c = c ^ 5'h15;
    end
    return c;
  endfunction

endpackage

// File: rtl/serchain_rst_sync.sv
module serchain_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_q_n = sync_q[1];
endmodule

// File: rtl/serchain_clkdiv.sv
module serchain_clkdiv #(
  parameter int CLK_DIV = 2
) (
  input  logic clk,
  input  logic rst_q_n,
  input  logic en_i,
  output logic tick_o
);
  localparam int CW = $clog2(CLK_DIV + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          wrap;

  assign wrap   = (cnt_q == CW'(CLK_DIV - 1));
  assign tick_o = en_i && wrap;

  always_comb begin
    if (!en_i)     cnt_d = '0;
    else if (wrap) cnt_d = '0;
    else           cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) cnt_q <= '0;
    else          cnt_q <= cnt_d;
  end
endmodule

// File: rtl/serchain_chip_diag.sv
module serchain_chip_diag #(
  parameter int HAS_STATUS = 1
) (
  input  logic [7:0] in_byte_i,
  input  logic [7:0] stat_i,
  input  logic       pin_i,
  input  logic       ignore_uv_i,
  output logic [7:0] data_o,
  output logic       crc_err_o,
  output logic       otemp_o,
  output logic       uv_alarm_o,
  output logic       uv_warn_o,
  output logic       faulty_o
);
  logic pin_hit;

  generate
    if (HAS_STATUS != 0) begin : g_stat
      logic [4:0] crc_exp;
      assign crc_exp    = serchain_pkg::crc5_calc(in_byte_i);
      assign crc_err_o  = (stat_i[7:3] != crc_exp);
      assign otemp_o    = stat_i[1];
      assign uv_alarm_o = !ignore_uv_i && !stat_i[2];
      assign uv_warn_o  = !ignore_uv_i && !stat_i[0];
    end else begin : g_lean
      assign crc_err_o  = 1'b0;
      assign otemp_o    = 1'b0;
      assign uv_alarm_o = 1'b0;
      assign uv_warn_o  = 1'b0;
    end
  endgenerate

  assign pin_hit  = pin_i && !ignore_uv_i;
  assign faulty_o = pin_hit || crc_err_o || otemp_o || uv_alarm_o;
  assign data_o   = faulty_o ? 8'h00 : in_byte_i;
endmodule

// File: rtl/serchain_reader.sv
module serchain_reader #(
  parameter int N_CHIPS   = 3,
  parameter int STATUS_EN = 1,
  parameter int FAULT_W   = 3,
  parameter int CLK_DIV   = 2,
  parameter int CPOL      = 0,
  parameter int CPHA      = 0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start_i,
  input  logic                   ignore_uv_i,
  input  logic [FAULT_W-1:0]     fault_pin_i,
  input  logic [2*N_CHIPS-1:0]   dbnc_sel_i,
  input  logic                   miso_i,
  output logic                   sclk_o,
  output logic                   cs_n_o,
  output logic                   modesel_o,
  output logic [N_CHIPS-1:0]     db0_o,
  output logic [N_CHIPS-1:0]     db1_o,
  output logic                   done_o,
  output logic [8*N_CHIPS-1:0]   data_o,
  output logic [N_CHIPS-1:0]     fault_o,
  output logic [N_CHIPS-1:0]     crc_err_o,
  output logic [N_CHIPS-1:0]     otemp_o,
  output logic [N_CHIPS-1:0]     uv_alarm_o,
  output logic [N_CHIPS-1:0]     uv_warn_o
);
  import serchain_pkg::*;

  localparam int W     = (STATUS_EN != 0) ? 2 : 1;
  localparam int NBITS = 8 * W * N_CHIPS;
  localparam int NEDGE = 2 * NBITS;
  localparam int EW    = $clog2(NEDGE + 1);
  localparam logic IDLE_LVL = (CPOL != 0);

  logic rst_q_n;
  logic tick;

  rd_state_e        st_q, st_d;
  logic [EW-1:0]    edge_q, edge_d;
  logic             sclk_q, sclk_d;
  logic             cs_q, cs_d;
  logic [NBITS-1:0] shreg_q, shreg_d;
  logic             lead_edge, take_bit, load;

  logic [8*N_CHIPS-1:0] data_d;
  logic [N_CHIPS-1:0]   fault_d, crc_d, ot_d, uva_d, uvw_d;
  logic [8*N_CHIPS-1:0] data_q;
  logic [N_CHIPS-1:0]   fault_q, crc_q, ot_q, uva_q, uvw_q;
  logic                 done_q;
  logic [N_CHIPS-1:0]   db0_q, db1_q, db0_d, db1_d;

  serchain_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_q_n(rst_q_n)
  );

  serchain_clkdiv #(.CLK_DIV(CLK_DIV)) u_div (
    .clk    (clk),
    .rst_q_n(rst_q_n),
    .en_i   ((st_q == ST_SETUP) || (st_q == ST_CLK) || (st_q == ST_HOLD)),
    .tick_o (tick)
  );

  // even edge index = leading edge away from idle level
  assign lead_edge = !edge_q[0];
  assign take_bit  = (CPHA != 0) ? !lead_edge : lead_edge;

  always_comb begin
    st_d    = st_q;
    edge_d  = edge_q;
    sclk_d  = sclk_q;
    cs_d    = cs_q;
    shreg_d = shreg_q;
    case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          st_d = ST_SETUP;
          cs_d = 1'b0;
        end
      end
      ST_SETUP: begin
        if (tick) begin
          st_d   = ST_CLK;
          edge_d = '0;
        end
      end
      ST_CLK: begin
        if (tick) begin
          sclk_d = !sclk_q;
          edge_d = edge_q + 1'b1;
          if (take_bit) shreg_d = {shreg_q[NBITS-2:0], miso_i};
          if (edge_q == EW'(NEDGE - 1)) st_d = ST_HOLD;
        end
      end
      ST_HOLD: begin
        if (tick) begin
          cs_d = 1'b1;
          st_d = ST_FIN;
        end
      end
      ST_FIN:  st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      st_q    <= ST_IDLE;
      edge_q  <= '0;
      sclk_q  <= IDLE_LVL;
      cs_q    <= 1'b1;
      shreg_q <= '0;
    end else begin
      st_q    <= st_d;
      edge_q  <= edge_d;
      sclk_q  <= sclk_d;
      cs_q    <= cs_d;
      shreg_q <= shreg_d;
    end
  end

  // per-chip slot decode: chip 0 occupies the top of the frame
  genvar gi;
  generate
    for (gi = 0; gi < N_CHIPS; gi++) begin : g_chip
      localparam int TOP = NBITS - 1 - 8 * W * gi;
      logic [7:0] stat_b;
      logic       pin_b;
      if (STATUS_EN != 0) begin : g_s
        assign stat_b = shreg_q[TOP-8 -: 8];
      end else begin : g_n
        assign stat_b = 8'h00;
      end
      if (FAULT_W == 1) begin : g_shared
        assign pin_b = fault_pin_i[0];
      end else begin : g_own
        assign pin_b = fault_pin_i[gi];
      end
      serchain_chip_diag #(.HAS_STATUS(STATUS_EN)) u_diag (
        .in_byte_i  (shreg_q[TOP -: 8]),
        .stat_i     (stat_b),
        .pin_i      (pin_b),
        .ignore_uv_i(ignore_uv_i),
        .data_o     (data_d[8*gi +: 8]),
        .crc_err_o  (crc_d[gi]),
        .otemp_o    (ot_d[gi]),
        .uv_alarm_o (uva_d[gi]),
        .uv_warn_o  (uvw_d[gi]),
        .faulty_o   (fault_d[gi])
      );
      assign db0_d[gi] = dbnc_sel_i[2*gi];
      assign db1_d[gi] = dbnc_sel_i[2*gi+1];
    end
  endgenerate

  assign load = (st_q == ST_FIN);

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      data_q  <= '0;
      fault_q <= '0;
      crc_q   <= '0;
      ot_q    <= '0;
      uva_q   <= '0;
      uvw_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= load;
      if (load) begin
        data_q  <= data_d;
        fault_q <= fault_d;
        crc_q   <= crc_d;
        ot_q    <= ot_d;
        uva_q   <= uva_d;
        uvw_q   <= uvw_d;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      db0_q <= '0;
      db1_q <= '0;
    end else if (st_q == ST_IDLE) begin
      db0_q <= db0_d;
      db1_q <= db1_d;
    end
  end

  assign sclk_o     = sclk_q;
  assign cs_n_o     = cs_q;
  assign modesel_o  = (STATUS_EN == 0);
  assign db0_o      = db0_q;
  assign db1_o      = db1_q;
  assign done_o     = done_q;
  assign data_o     = data_q;
  assign fault_o    = fault_q;
  assign crc_err_o  = crc_q;
  assign otemp_o    = ot_q;
  assign uv_alarm_o = uva_q;
  assign uv_warn_o  = uvw_q;

  // ---------------- assertions ----------------
  logic [EW-1:0] chk_act_q;
  logic          chk_sclk_q;

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      chk_act_q  <= '0;
      chk_sclk_q <= IDLE_LVL;
    end else begin
      chk_sclk_q <= sclk_o;
      if (cs_n_o) chk_act_q <= '0;
      else if ((sclk_o != IDLE_LVL) && (chk_sclk_q == IDLE_LVL)) chk_act_q <= chk_act_q + 1'b1;
    end
  end

  p_sclk_idle_r1: assert property (@(posedge clk) disable iff (!rst_q_n)
    cs_n_o |-> (sclk_o == IDLE_LVL));

  p_clock_count_r1: assert property (@(posedge clk) disable iff (!rst_q_n)
    $rose(cs_n_o) |-> (chk_act_q == EW'(NBITS)));

  p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_q_n)
    done_o |=> !done_o);

  p_hold_data_r2: assert property (@(posedge clk) disable iff (!rst_q_n)
    !done_o |-> ($stable(data_o) && $stable(fault_o)));

  p_db_frozen_r11: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!cs_n_o && !$past(cs_n_o)) |-> ($stable(db0_o) && $stable(db1_o)));

endmodule

// File: tb/tb_serchain_reader.sv
module tb_chain_slave #(
  parameter int NB = 6
) (
  input  logic            cs_n,
  input  logic            sclk,
  input  logic [8*NB-1:0] frame,
  output logic            miso
);
  int idx;
  initial begin
    miso = 1'b0;
    idx  = 0;
  end
  always @(negedge cs_n) begin
    idx  = 0;
    miso = frame[8*NB-1];
  end
  always @(negedge sclk) begin
    if (!cs_n) begin
      idx = idx + 1;
      if (idx < 8*NB) miso = frame[8*NB-1-idx];
    end
  end
endmodule

module tb_serchain_reader;
  localparam int CLK_PERIOD = 10;

  logic clk, rst_n;
  int   checks, errors;
  bit   finished;

  // status-mode chain of three chips, one fault line per chip
  logic        start_a, ign_a, miso_a, sclk_a, cs_a, mod_a, done_a;
  logic [2:0]  pin_a, db0_a, db1_a, flt_a, crc_a, ot_a, uva_a, uvw_a;
  logic [5:0]  dsel_a;
  logic [23:0] data_a;
  logic [47:0] frame_a;

  // lean-mode chain of two chips, shared fault line
  logic        start_b, ign_b, miso_b, sclk_b, cs_b, mod_b, done_b;
  logic [0:0]  pin_b;
  logic [1:0]  db0_b, db1_b, flt_b, crc_b, ot_b, uva_b, uvw_b;
  logic [15:0] data_b;
  logic [15:0] frame_b;

  int rise_a, rise_b, dones_a;

  serchain_reader dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_a), .ignore_uv_i(ign_a),
    .fault_pin_i(pin_a), .dbnc_sel_i(dsel_a), .miso_i(miso_a),
    .sclk_o(sclk_a), .cs_n_o(cs_a), .modesel_o(mod_a), .db0_o(db0_a), .db1_o(db1_a),
    .done_o(done_a), .data_o(data_a), .fault_o(flt_a), .crc_err_o(crc_a),
    .otemp_o(ot_a), .uv_alarm_o(uva_a), .uv_warn_o(uvw_a)
  );

  serchain_reader #(.N_CHIPS(2), .STATUS_EN(0), .FAULT_W(1)) dut_b (
    .clk(clk), .rst_n(rst_n), .start_i(start_b), .ignore_uv_i(ign_b),
    .fault_pin_i(pin_b), .dbnc_sel_i(4'b0000), .miso_i(miso_b),
    .sclk_o(sclk_b), .cs_n_o(cs_b), .modesel_o(mod_b), .db0_o(db0_b), .db1_o(db1_b),
    .done_o(done_b), .data_o(data_b), .fault_o(flt_b), .crc_err_o(crc_b),
    .otemp_o(ot_b), .uv_alarm_o(uva_b), .uv_warn_o(uvw_b)
  );

  tb_chain_slave #(.NB(6)) u_sl_a (.cs_n(cs_a), .sclk(sclk_a), .frame(frame_a), .miso(miso_a));
  tb_chain_slave #(.NB(2)) u_sl_b (.cs_n(cs_b), .sclk(sclk_b), .frame(frame_b), .miso(miso_b));

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = !clk;

  always @(posedge sclk_a) if (!cs_a) rise_a++;
  always @(posedge sclk_b) if (!cs_b) rise_b++;
  always @(negedge clk) if (done_a) dones_a++;

  // independent reference: byte-wide CRC with left-aligned generator
  function automatic logic [4:0] ref_crc(input logic [7:0] d);
    logic [7:0] c;
    c = d;
    for (int i = 0; i < 8; i++) c = c[7] ? ((c << 1) ^ 8'hA8) : (c << 1);
    return c[7:3];
  endfunction

  // healthy status byte: CRC, bit2=1 (supply ok), bit1=0, bit0=1
  function automatic logic [7:0] good_st(input logic [7:0] d);
    return {ref_crc(d), 3'b101};
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic run_a;
    int n;
    rise_a = 0;
    @(negedge clk) start_a = 1'b1;
    @(negedge clk) start_a = 1'b0;
    n = 0;
    while (!done_a && n < 3000) begin
      @(negedge clk);
      n++;
    end
    check("R2 done seen (a)", done_a, 1'b1);
  endtask

  task automatic run_b;
    int n;
    rise_b = 0;
    @(negedge clk) start_b = 1'b1;
    @(negedge clk) start_b = 1'b0;
    n = 0;
    while (!done_b && n < 3000) begin
      @(negedge clk);
      n++;
    end
    check("R2 done seen (b)", done_b, 1'b1);
  endtask

  task automatic t_reset;
    check("R1 cs idle after reset", cs_a, 1'b1);
    check("R1 sclk idle after reset", sclk_a, 1'b0);
    check("R2 done low after reset", done_a, 1'b0);
    check("R2 data zero after reset", data_a, 24'h0);
    check("R10 modesel status mode", mod_a, 1'b0);
    check("R10 modesel lean mode", mod_b, 1'b1);
  endtask

  task automatic t_healthy;
    frame_a = {8'hA5, good_st(8'hA5), 8'h3C, good_st(8'h3C), 8'h81, good_st(8'h81)};
    run_a();
    check("R3 chip order and bit map", data_a, 24'h813CA5);
    check("R9 no fault on healthy chain", flt_a, 3'b000);
    check("R4 no crc error", crc_a, 3'b000);
    check("R1 clock count 48", rise_a, 48);
    @(negedge clk);
    check("R2 done one cycle", done_a, 1'b0);
    repeat (20) @(negedge clk);
    check("R2 data held", data_a, 24'h813CA5);
    check("R1 sclk idle between frames", sclk_a, 1'b0);
  endtask

  task automatic t_crc;
    logic [7:0] bad;
    bad = good_st(8'h3C) ^ 8'h40;
    frame_a = {8'hA5, good_st(8'hA5), 8'h3C, bad, 8'h81, good_st(8'h81)};
    run_a();
    check("R4 crc flag on chip1", crc_a, 3'b010);
    check("R4 crc fault on chip1", flt_a, 3'b010);
    check("R9 chip1 masked, others kept", data_a, 24'h8100A5);
  endtask

  task automatic t_otemp;
    frame_a = {8'h11, good_st(8'h11), 8'h22, good_st(8'h22), 8'h7E, good_st(8'h7E) | 8'h02};
    run_a();
    check("R5 otemp flag chip2", ot_a, 3'b100);
    check("R5 otemp fault chip2", flt_a, 3'b100);
    check("R9 chip2 masked", data_a, 24'h002211);
  endtask

  task automatic t_uv;
    frame_a = {8'hC3, good_st(8'hC3) & 8'hFB, 8'h5A, good_st(8'h5A) & 8'hFE, 8'h0F, good_st(8'h0F)};
    ign_a = 1'b0;
    run_a();
    check("R6 uv alarm chip0", uva_a, 3'b001);
    check("R6 uv warn chip1", uvw_a, 3'b010);
    check("R6 warning alone not faulty", flt_a, 3'b001);
    check("R6 data with warning kept", data_a, 24'h0F5A00);
    ign_a = 1'b1;
    pin_a = 3'b100;
    run_a();
    check("R7 uv alarm suppressed", uva_a, 3'b000);
    check("R7 uv warn suppressed", uvw_a, 3'b000);
    check("R7 fault lines ignored", flt_a, 3'b000);
    check("R7 data all present", data_a, 24'h0F5AC3);
    ign_a = 1'b0;
  endtask

  task automatic t_pins;
    frame_a = {8'hA5, good_st(8'hA5), 8'h3C, good_st(8'h3C), 8'h81, good_st(8'h81)};
    pin_a = 3'b100;
    run_a();
    check("R8 per-chip fault line", flt_a, 3'b100);
    check("R8 other chips kept", data_a, 24'h003CA5);
    pin_a = 3'b000;
  endtask

  task automatic t_lean;
    frame_b = {8'h96, 8'h4B};
    pin_b = 1'b0;
    ign_b = 1'b0;
    run_b();
    check("R10 lean data", data_b, 16'h4B96);
    check("R10 lean clock count 16", rise_b, 16);
    check("R10 lean status flags zero", {crc_b, ot_b, uva_b, uvw_b}, 8'h00);
    check("R10 lean no fault", flt_b, 2'b00);
    pin_b = 1'b1;
    run_b();
    check("R8 shared line faults all", flt_b, 2'b11);
    check("R9 lean masked", data_b, 16'h0000);
    ign_b = 1'b1;
    run_b();
    check("R7 shared line ignored", flt_b, 2'b00);
    pin_b = 1'b0;
    ign_b = 1'b0;
  endtask

  task automatic t_debounce_busy;
    int d0;
    dsel_a = 6'b10_01_11;
    repeat (2) @(negedge clk);
    check("R11 db0 lines", db0_a, 3'b011);
    check("R11 db1 lines", db1_a, 3'b101);
    frame_a = {8'hA5, good_st(8'hA5), 8'h3C, good_st(8'h3C), 8'h81, good_st(8'h81)};
    d0 = dones_a;
    rise_a = 0;
    @(negedge clk) start_a = 1'b1;
    @(negedge clk) start_a = 1'b0;
    repeat (30) @(negedge clk);
    dsel_a = 6'b00_00_00;
    start_a = 1'b1;
    @(negedge clk) start_a = 1'b0;
    repeat (5) @(negedge clk);
    check("R11 db0 frozen mid-frame", db0_a, 3'b011);
    check("R11 db1 frozen mid-frame", db1_a, 3'b101);
    repeat (400) @(negedge clk);
    check("R2 busy start dropped", dones_a - d0, 1);
    check("R2 no second frame", cs_a, 1'b1);
    check("R11 db updated when idle", {db1_a, db0_a}, 6'b000000);
  endtask

  initial begin
    checks = 0; errors = 0; finished = 0;
    rise_a = 0; rise_b = 0; dones_a = 0;
    rst_n = 1'b0;
    start_a = 1'b0; ign_a = 1'b0; pin_a = 3'b000; dsel_a = 6'b0;
    start_b = 1'b0; ign_b = 1'b0; pin_b = 1'b0;
    frame_a = '0; frame_b = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_healthy();
    t_crc();
    t_otemp();
    t_uv();
    t_pins();
    t_lean();
    t_debounce_busy();
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule